// File: doc/BRIEF.md
# Locked-Rotor Timeout Guard

This block protects a three-phase brushless drive against a stalled rotor. It watches the three Hall sensor lines while the drive is running. If no Hall line changes for a programmable number of timebase ticks, it declares a stall. While the stall is declared, the block forces the high-side gate commands off and passes the low-side commands through unchanged. A single-cycle `tick_en` strobe stands in for the slow timing oscillator. The caller picks the tick rate and `timeout_limit` so that their product gives the wanted timeout, typically a couple of seconds.

A stall is sticky. It stays set until the power-save input is driven, and that same input also clears the elapsed count. Recovery therefore comes from cycling the controller through its idle level. A thermal-shutdown input pauses the count without discarding it. Every Hall edge restarts the count from zero. The counter stops at the limit and never wraps.

Top module: `rotor_stall_guard`

## Requirements
- R1: When the elapsed tick count reaches a nonzero `timeout_limit`, `stall_flag` goes high on the following clock edge. With `timeout_limit` = L, the flag is set one cycle after the L-th counted tick.
- R2: In every cycle after a cycle in which `stall_flag` is high, all bits of `gate_hi_out` are 0. When `stall_flag` is low, `gate_hi_out` equals `gate_hi_in` delayed by one cycle.
- R3: A cycle with `power_save` high clears `stall_flag` and the elapsed count on that edge. This takes priority over every other input.
- R4: While `thermal_hold` is high, ticks are ignored and the elapsed count keeps its value. Counting resumes from that value once `thermal_hold` falls.
- R5: Any change on any bit of `hall_in` clears the elapsed count. The change passes through a synchronizer of `SYNC_STAGES` flops plus one compare register, so the clear takes effect `SYNC_STAGES`+1 edges after the change (3 with the defaults).
- R6: The count advances by one only on a cycle where both `tick_en` and `drive_en` are high. Ticks seen while `drive_en` is low have no effect.
- R7: Once set, `stall_flag` stays high until `power_save` is asserted. Hall changes and further ticks do not clear it.
- R8: The elapsed count saturates at `timeout_limit` and never wraps back to zero without a clear.
- R9: `gate_lo_out` equals `gate_lo_in` delayed by one cycle, regardless of the stall state.
- R10: A `timeout_limit` of 0 disables tripping. `stall_flag` stays low however many ticks arrive.
- R11: While `rst` is high, `stall_flag`, `gate_hi_out` and `gate_lo_out` are all 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | NUM_HALL | Raw Hall sensor levels (asynchronous) |
| drive_en | input | 1 | High while the drive is in run mode |
| power_save | input | 1 | Idle/power-save request; releases a stall and clears the count |
| thermal_hold | input | 1 | Thermal shutdown active; freezes the count |
| tick_en | input | 1 | One-cycle timebase strobe |
| timeout_limit | input | CNT_W | Ticks without a Hall edge before a stall; 0 disables |
| gate_hi_in | input | NUM_PH | Upstream high-side gate commands |
| gate_lo_in | input | NUM_PH | Upstream low-side gate commands |
| gate_hi_out | output | NUM_PH | Registered high-side commands, masked during a stall |
| gate_lo_out | output | NUM_PH | Registered low-side commands |
| stall_flag | output | 1 | Sticky stall status |

## Verification
The assertions assume that each Hall level is held for at least `SYNC_STAGES`+1 cycles. Under that assumption, every level reaches the compare stage and no glitch is filtered out of sight. They also assume that `timeout_limit` is not changed while a count is in progress. The stimulus moves Hall lines only from idle, waits out the synchronizer latency before issuing further ticks, and sets the limit once per scenario while `power_save` is held. Tick strobes are always single-cycle pulses separated by idle cycles, as the slow oscillator they replace would produce.

// File: rtl/stall_pkg.sv
package stall_pkg;

  typedef enum logic [1:0] {
    CNT_CLEAR = 2'd0,
    CNT_HOLD  = 2'd1,
    CNT_STEP  = 2'd2
  } cnt_action_e;

  function automatic cnt_action_e pick_action(
    input logic clear_req,
    input logic freeze_req,
    input logic step_req
  );
    if (clear_req)       return CNT_CLEAR;
    else if (freeze_req) return CNT_HOLD;
    else if (step_req)   return CNT_STEP;
    else                 return CNT_HOLD;
  endfunction

endpackage

// File: rtl/stall_hall_watch.sv
module stall_hall_watch #(
  parameter int NUM_HALL    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_HALL-1:0] hall_raw,
  output logic                hall_chg
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_HALL-1:0] pipe [SYNC_STAGES];
  logic [NUM_HALL-1:0] prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= hall_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pipe[LAST];
  end

  assign hall_chg = |(pipe[LAST] ^ prev_q);

endmodule

// File: rtl/stall_timer.sv
module stall_timer
  import stall_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             power_save,
  input  logic             hall_chg,
  input  logic             thermal_hold,
  input  logic             drive_en,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             stall
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  cnt_action_e act;
  logic        armed;
  logic        at_limit;

  assign armed    = (limit != '0);
  assign at_limit = armed && (cnt >= limit);

  always_comb begin
    act = pick_action(power_save || hall_chg,
                      thermal_hold || !armed || at_limit,
                      drive_en && tick_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case (act)
        CNT_CLEAR: cnt <= '0;
        CNT_STEP:  cnt <= cnt + ONE;
        default:   cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || power_save) stall <= 1'b0;
    else if (at_limit)     stall <= 1'b1;
  end

endmodule

// File: rtl/stall_gate_mask.sv
module stall_gate_mask #(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [NUM_PH-1:0] hi_in,
  input  logic [NUM_PH-1:0] lo_in,
  output logic [NUM_PH-1:0] hi_out,
  output logic [NUM_PH-1:0] lo_out
);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_out[p] <= 1'b0;
        lo_out[p] <= 1'b0;
      end else begin
        hi_out[p] <= hi_in[p] & ~stall;
        lo_out[p] <= lo_in[p];
      end
    end
  end
endmodule

// File: rtl/rotor_stall_guard.sv
module rotor_stall_guard #(
  parameter int NUM_HALL    = 3,
  parameter int NUM_PH      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_HALL-1:0] hall_in,
  input  logic                drive_en,
  input  logic                power_save,
  input  logic                thermal_hold,
  input  logic                tick_en,
  input  logic [CNT_W-1:0]    timeout_limit,
  input  logic [NUM_PH-1:0]   gate_hi_in,
  input  logic [NUM_PH-1:0]   gate_lo_in,
  output logic [NUM_PH-1:0]   gate_hi_out,
  output logic [NUM_PH-1:0]   gate_lo_out,
  output logic                stall_flag
);
  logic             hall_chg;
  logic [CNT_W-1:0] elapsed;
  logic             stall;

  stall_hall_watch #(
    .NUM_HALL    (NUM_HALL),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_watch (
    .clk      (clk),
    .rst      (rst),
    .hall_raw (hall_in),
    .hall_chg (hall_chg)
  );

  stall_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .power_save   (power_save),
    .hall_chg     (hall_chg),
    .thermal_hold (thermal_hold),
    .drive_en     (drive_en),
    .tick_en      (tick_en),
    .limit        (timeout_limit),
    .cnt          (elapsed),
    .stall        (stall)
  );

  stall_gate_mask #(
    .NUM_PH (NUM_PH)
  ) u_mask (
    .clk    (clk),
    .rst    (rst),
    .stall  (stall),
    .hi_in  (gate_hi_in),
    .lo_in  (gate_lo_in),
    .hi_out (gate_hi_out),
    .lo_out (gate_lo_out)
  );

  assign stall_flag = stall;

endmodule

// File: rtl/rotor_stall_guard_checker.sv
module rotor_stall_guard_checker #(
  parameter int NUM_PH = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              power_save,
  input logic              thermal_hold,
  input logic              hall_chg,
  input logic [CNT_W-1:0]  elapsed,
  input logic [CNT_W-1:0]  timeout_limit,
  input logic              stall_flag,
  input logic [NUM_PH-1:0] gate_hi_out,
  input logic [NUM_PH-1:0] gate_lo_in,
  input logic [NUM_PH-1:0] gate_lo_out
);
  // R1
  assert_trip_R1: assert property (@(posedge clk) disable iff (rst)
    (timeout_limit != '0 && elapsed >= timeout_limit && !power_save) |=> stall_flag);
  // R2
  assert_hi_off_R2: assert property (@(posedge clk) disable iff (rst)
    stall_flag |=> (gate_hi_out == '0));
  // R3
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    power_save |=> (!stall_flag && elapsed == '0));
  // R4
  assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (thermal_hold && !power_save && !hall_chg) |=> $stable(elapsed));
  // R5
  assert_hall_clear_R5: assert property (@(posedge clk) disable iff (rst)
    hall_chg |=> (elapsed == '0));
  // R7
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (stall_flag && !power_save) |=> stall_flag);
  // R8
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (elapsed != '0 && !power_save && !hall_chg) |=> (elapsed != '0));
  // R9
  assert_lo_pass_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gate_lo_out == $past(gate_lo_in)));
endmodule

bind rotor_stall_guard rotor_stall_guard_checker #(
  .NUM_PH (NUM_PH),
  .CNT_W  (CNT_W)
) u_checker (
  .clk           (clk),
  .rst           (rst),
  .power_save    (power_save),
  .thermal_hold  (thermal_hold),
  .hall_chg      (hall_chg),
  .elapsed       (elapsed),
  .timeout_limit (timeout_limit),
  .stall_flag    (stall_flag),
  .gate_hi_out   (gate_hi_out),
  .gate_lo_in    (gate_lo_in),
  .gate_lo_out   (gate_lo_out)
);

// File: tb/rotor_stall_guard_bench.sv
module rotor_stall_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int LIM        = 5;
  localparam int HALL_LAT   = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic [2:0]       hall_in;
  logic             drive_en, power_save, thermal_hold, tick_en;
  logic [CNT_W-1:0] timeout_limit;
  logic [2:0]       gate_hi_in, gate_lo_in;
  logic [2:0]       gate_hi_out, gate_lo_out;
  logic             stall_flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotor_stall_guard u_rotor_stall_guard (
    .clk(clk), .rst(rst), .hall_in(hall_in), .drive_en(drive_en),
    .power_save(power_save), .thermal_hold(thermal_hold), .tick_en(tick_en),
    .timeout_limit(timeout_limit), .gate_hi_in(gate_hi_in), .gate_lo_in(gate_lo_in),
    .gate_hi_out(gate_hi_out), .gate_lo_out(gate_lo_out), .stall_flag(stall_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic release_guard(input int lim);
    power_save = 1'b1;
    timeout_limit = CNT_W'(lim);
    @(negedge clk);
    power_save = 1'b0;
    @(negedge clk);
  endtask

  task automatic flip_hall();
    hall_in = {hall_in[1:0], ~hall_in[2]};
    cycles(HALL_LAT + 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cycles(2);
    check("R11 stall", int'(stall_flag), 0);
    check("R11 hi", int'(gate_hi_out), 0);
    check("R11 lo", int'(gate_lo_out), 0);
    rst = 1'b0;
    cycles(HALL_LAT + 1);
  endtask

  task automatic t_trip();
    release_guard(LIM);
    ticks(LIM - 1);
    check("R1 no trip before limit", int'(stall_flag), 0);
    check("R2 hi passes when clear", int'(gate_hi_out), int'(gate_hi_in));
    ticks(1);
    check("R1 trip at limit", int'(stall_flag), 1);
    cycles(1);
    check("R2 hi masked", int'(gate_hi_out), 0);
    check("R9 lo passes in stall", int'(gate_lo_out), int'(gate_lo_in));
    gate_lo_in = 3'b100;
    cycles(1);
    check("R9 lo follows input", int'(gate_lo_out), 4);
    gate_lo_in = 3'b010;
  endtask

  task automatic t_sticky();
    flip_hall();
    ticks(3 * LIM);
    check("R7 sticky after hall edge", int'(stall_flag), 1);
    check("R8 still tripped after extra ticks", int'(stall_flag), 1);
    check("R2 hi still masked", int'(gate_hi_out), 0);
  endtask

  task automatic t_power_save();
    power_save = 1'b1;
    ticks(2);
    check("R3 released", int'(stall_flag), 0);
    power_save = 1'b0;
    cycles(1);
    check("R2 hi restored", int'(gate_hi_out), int'(gate_hi_in));
    ticks(LIM - 1);
    check("R3 count cleared", int'(stall_flag), 0);
    ticks(1);
    check("R3 counts again from zero", int'(stall_flag), 1);
  endtask

  task automatic t_hall_clear();
    release_guard(LIM);
    ticks(LIM - 1);
    flip_hall();
    ticks(LIM - 1);
    check("R5 hall edge restarts count", int'(stall_flag), 0);
    ticks(1);
    check("R5 trip after fresh window", int'(stall_flag), 1);
  endtask

  task automatic t_thermal();
    release_guard(LIM);
    ticks(LIM - 1);
    thermal_hold = 1'b1;
    ticks(2 * LIM);
    check("R4 frozen no trip", int'(stall_flag), 0);
    thermal_hold = 1'b0;
    ticks(1);
    check("R4 count kept through freeze", int'(stall_flag), 1);
  endtask

  task automatic t_drive_gate();
    release_guard(LIM);
    drive_en = 1'b0;
    ticks(2 * LIM);
    check("R6 ticks ignored when idle", int'(stall_flag), 0);
    drive_en = 1'b1;
    cycles(3);
    check("R6 no trip without ticks", int'(stall_flag), 0);
    ticks(LIM);
    check("R6 counts in drive", int'(stall_flag), 1);
  endtask

  task automatic t_limit_zero();
    release_guard(0);
    ticks(3 * LIM);
    check("R10 zero limit never trips", int'(stall_flag), 0);
    check("R10 hi passes", int'(gate_hi_out), int'(gate_hi_in));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; hall_in = 3'b001; drive_en = 1'b1; power_save = 1'b0;
    thermal_hold = 1'b0; tick_en = 1'b0; timeout_limit = CNT_W'(LIM);
    gate_hi_in = 3'b101; gate_lo_in = 3'b010;
    @(negedge clk);
    t_reset();
    t_trip();
    t_sticky();
    t_power_save();
    t_hall_clear();
    t_thermal();
    t_drive_gate();
    t_limit_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule